// File: doc/BRIEF.md
# CPU Error Status and Kernel Stack Limit Monitor

This block sits beside the execution unit of a 16-bit minicomputer-style core. It watches the per-access result of every memory cycle and records why things went wrong in a sticky error status register. It also checks each kernel-mode stack push against two low-address limits. A push that lands in the yellow zone raises a trap request but is allowed to complete. A push that lands in the red zone, or any push that itself aborts, raises a fatal red-stack abort request. The underlying abort cause is recorded next to the red-stack bit.

A HALT that the core attempts outside kernel mode is reported on a separate strobe. The block records it and raises a trap request. Software reads the status word through a simple read port. Any write strobe clears the whole word. Decoding, vectoring and the push itself stay in the core. This block only classifies events and records them.

Top module: `cpuerr_stack_mon`

## Requirements
- R1: After reset the status word `err_q` reads 0 and no request output (`yel_trap`, `red_abort`, `halt_trap`) is active.
- R2: A write strobe `reg_wr` clears every bit of the status word. The status word then reads 0 in the next cycle, unless an event in the same cycle sets new bits (R11).
- R3: A kernel stack push without an abort to an address from 0340 to 0377 (octal) pulses `yel_trap` and sets the yellow bit 010. `red_abort` stays low.
- R4: A kernel stack push without an abort to an address below 0340 pulses `red_abort` and sets only the red-stack bit 004. `yel_trap` stays low.
- R5: A kernel push without an abort at 0400 or above causes no request and no status change. A stack push outside kernel mode is never zone-checked.
- R6: A kernel stack push that fails with an odd-address abort pulses `red_abort` and sets 0104 (red stack plus address error). This holds in any zone, so a yellow trap is never raised for an aborted push.
- R7: A kernel stack push that fails with an I/O bus timeout pulses `red_abort` and sets 024.
- R8: A kernel stack push that fails with an MMU abort, or with a non-existent-memory abort, pulses `red_abort` and sets 0104.
- R9: An abort on any access other than a kernel stack push records its cause without a request. Odd address sets 0100, non-existent memory sets 040, I/O bus timeout sets 020, and an MMU abort sets nothing.
- R10: A strobe on `halt_user` sets bit 0200 and pulses `halt_trap`.
- R11: Status bits accumulate by OR until a write. An event in the same cycle as a write survives the clear.
- R12: Requests and status updates appear on the clock edge that samples the event. Each request is one cycle wide per event. Access inputs are ignored while `acc_valid` is low.
- R13: Only bits 0374 of the status word can ever be set. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access result is presented this cycle |
| acc_push | input | 1 | The access is a stack push |
| acc_kernel | input | 1 | The access is made in kernel mode |
| acc_addr | input | 16 | Target address of the access |
| ab_odd | input | 1 | Access aborted: odd address |
| ab_nxm | input | 1 | Access aborted: non-existent memory |
| ab_iobto | input | 1 | Access aborted: I/O bus timeout |
| ab_mmu | input | 1 | Access aborted: MMU abort |
| halt_user | input | 1 | HALT attempted outside kernel mode |
| reg_wr | input | 1 | Status register write strobe (data ignored) |
| yel_trap | output | 1 | Yellow-zone trap request |
| red_abort | output | 1 | Red-stack abort request |
| halt_trap | output | 1 | Illegal-halt trap request |
| err_q | output | 16 | Error status word |

## Verification
The zone edges are probed on both sides: 0337 against 0340, and 0377 against 0400. A limit compare that is off by one would misplace a trap there. Pushes that abort inside the yellow zone show whether the abort path wins; a design that checked the zone first would raise a yellow trap and lose the cause bit. A user-mode push to a red address and an MMU abort on a plain access show whether the design records only what it should. A write in the same cycle as a HALT shows whether the clear or the new event wins. The last test sets every cause together and expects exactly 0374, which catches a wrong bit position.

// File: rtl/cpuerr_pkg.sv
package cpuerr_pkg;

  localparam int unsigned ERR_W = 16;

  // status word bit positions (values are octal weights)
  localparam int unsigned B_ILLHLT = 7;  // 0200
  localparam int unsigned B_ODDADR = 6;  // 0100
  localparam int unsigned B_NXMEM  = 5;  // 0040
  localparam int unsigned B_IOBTO  = 4;  // 0020
  localparam int unsigned B_YELSTK = 3;  // 0010
  localparam int unsigned B_REDSTK = 2;  // 0004

  localparam logic [ERR_W-1:0] IMPL_MASK =
    ERR_W'((1 << B_ILLHLT) | (1 << B_ODDADR) | (1 << B_NXMEM) |
           (1 << B_IOBTO)  | (1 << B_YELSTK) | (1 << B_REDSTK));

  typedef struct packed {
    logic odd;
    logic nxm;
    logic iobto;
    logic mmu;
  } abort_t;

  typedef enum logic [1:0] {
    ZONE_SAFE = 2'd0,
    ZONE_YEL  = 2'd1,
    ZONE_RED  = 2'd2
  } zone_e;

  localparam int unsigned N_REQ = 3;
  localparam int unsigned RQ_YEL  = 0;
  localparam int unsigned RQ_RED  = 1;
  localparam int unsigned RQ_HALT = 2;

endpackage

// File: rtl/stack_zone_check.sv
module stack_zone_check
  import cpuerr_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned YEL_LIM = 'o400,
  parameter int unsigned RED_LIM = 'o340
) (
  input  logic [AW-1:0] addr,
  output zone_e         zone
);

  localparam logic [AW-1:0] YEL_BOUND = AW'(YEL_LIM);
  localparam logic [AW-1:0] RED_BOUND = AW'(RED_LIM);

  logic below_red;
  logic below_yel;

  always_comb begin
    below_red = (addr < RED_BOUND);
    below_yel = (addr < YEL_BOUND);
    if (below_red)      zone = ZONE_RED;
    else if (below_yel) zone = ZONE_YEL;
    else                zone = ZONE_SAFE;
  end

endmodule

// File: rtl/cause_encoder.sv
module cause_encoder
  import cpuerr_pkg::*;
(
  input  logic              valid,
  input  logic              push,
  input  logic              kernel,
  input  zone_e             zone,
  input  abort_t            ab,
  input  logic              halt,
  output logic [ERR_W-1:0]  set_bits,
  output logic [N_REQ-1:0]  req
);

  logic kpush;
  logic any_ab;

  always_comb begin
    kpush    = valid & push & kernel;
    any_ab   = ab.odd | ab.nxm | ab.iobto | ab.mmu;
    set_bits = '0;
    req      = '0;

    if (kpush && any_ab) begin
      // failed kernel push: fatal, cause recorded beside red stack
      set_bits[B_REDSTK] = 1'b1;
      set_bits[B_ODDADR] = ab.odd | ab.mmu | ab.nxm;
      set_bits[B_IOBTO]  = ab.iobto;
      req[RQ_RED]        = 1'b1;
    end else if (kpush && (zone == ZONE_RED)) begin
      set_bits[B_REDSTK] = 1'b1;
      req[RQ_RED]        = 1'b1;
    end else if (kpush && (zone == ZONE_YEL)) begin
      set_bits[B_YELSTK] = 1'b1;
      req[RQ_YEL]        = 1'b1;
    end else if (valid && !kpush) begin
      set_bits[B_ODDADR] = ab.odd;
      set_bits[B_NXMEM]  = ab.nxm;
      set_bits[B_IOBTO]  = ab.iobto;
    end

    if (halt) begin
      set_bits[B_ILLHLT] = 1'b1;
      req[RQ_HALT]       = 1'b1;
    end
  end

endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import cpuerr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ERR_W-1:0]  set_bits,
  output logic [ERR_W-1:0]  q
);

  logic [ERR_W-1:0] q_r;
  logic [ERR_W-1:0] q_nxt;
  logic             q_en;

  always_comb begin
    q_en  = clr | (|set_bits);
    q_nxt = ((clr ? '0 : q_r) | set_bits) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/req_pulse_reg.sv
module req_pulse_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_req
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= 1'b0;
      else        r <= d[i];
    end
    assign q[i] = r;
  end

endmodule

// File: rtl/cpuerr_stack_mon.sv
module cpuerr_stack_mon
  import cpuerr_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned YEL_LIM = 'o400,
  parameter int unsigned RED_LIM = 'o340
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_push,
  input  logic              acc_kernel,
  input  logic [AW-1:0]     acc_addr,
  input  logic              ab_odd,
  input  logic              ab_nxm,
  input  logic              ab_iobto,
  input  logic              ab_mmu,
  input  logic              halt_user,
  input  logic              reg_wr,
  output logic              yel_trap,
  output logic              red_abort,
  output logic              halt_trap,
  output logic [ERR_W-1:0]  err_q
);

  zone_e             zone;
  abort_t            ab;
  logic [ERR_W-1:0]  set_bits;
  logic [N_REQ-1:0]  req_d;
  logic [N_REQ-1:0]  req_q;

  assign ab = '{odd: ab_odd, nxm: ab_nxm, iobto: ab_iobto, mmu: ab_mmu};

  stack_zone_check #(
    .AW      (AW),
    .YEL_LIM (YEL_LIM),
    .RED_LIM (RED_LIM)
  ) u_zone (
    .addr (acc_addr),
    .zone (zone)
  );

  cause_encoder u_enc (
    .valid    (acc_valid),
    .push     (acc_push),
    .kernel   (acc_kernel),
    .zone     (zone),
    .ab       (ab),
    .halt     (halt_user),
    .set_bits (set_bits),
    .req      (req_d)
  );

  err_status_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (reg_wr),
    .set_bits (set_bits),
    .q        (err_q)
  );

  req_pulse_reg #(.N(N_REQ)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_d),
    .q     (req_q)
  );

  assign yel_trap  = req_q[RQ_YEL];
  assign red_abort = req_q[RQ_RED];
  assign halt_trap = req_q[RQ_HALT];

endmodule

// File: rtl/cpuerr_stack_mon_chk.sv
module cpuerr_stack_mon_chk
  import cpuerr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              halt_user,
  input logic              reg_wr,
  input logic              yel_trap,
  input logic              red_abort,
  input logic              halt_trap,
  input logic [ERR_W-1:0]  err_q
);

  a_r3_zone_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(yel_trap && red_abort));

  a_r4_red_records: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |-> err_q[B_REDSTK]);

  a_r3_yel_records: assert property (@(posedge clk) disable iff (!rst_n)
    yel_trap |-> err_q[B_YELSTK]);

  a_r10_halt_records: assert property (@(posedge clk) disable iff (!rst_n)
    halt_trap |-> err_q[B_ILLHLT]);

  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !halt_user) |=> (!yel_trap && !red_abort && !halt_trap));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !acc_valid && !halt_user) |=> (err_q == '0));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((err_q & $past(err_q)) == $past(err_q)));

  a_r13_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & ~IMPL_MASK) == '0);

endmodule

bind cpuerr_stack_mon cpuerr_stack_mon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .halt_user (halt_user),
  .reg_wr    (reg_wr),
  .yel_trap  (yel_trap),
  .red_abort (red_abort),
  .halt_trap (halt_trap),
  .err_q     (err_q)
);

// File: tb/sim_cpuerr_stack_mon.sv
module sim_cpuerr_stack_mon;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // {push, kernel, addr[15:0], odd, nxm, iobto, mmu, exp_err[15:0], exp_yel, exp_red}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'o000400, 4'b0000, 16'o000, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'o000377, 4'b0000, 16'o010, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'o000340, 4'b0000, 16'o010, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'o000337, 4'b0000, 16'o004, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'o000000, 4'b0000, 16'o004, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'o001001, 4'b1000, 16'o104, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'o160004, 4'b0010, 16'o024, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'o020004, 4'b0001, 16'o104, 1'b0, 1'b1},
    {1'b1, 1'b1, 16'o140004, 4'b0100, 16'o104, 1'b0, 1'b1},
    {1'b0, 1'b1, 16'o001001, 4'b1000, 16'o100, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'o140000, 4'b0100, 16'o040, 1'b0, 1'b0},
    {1'b0, 1'b0, 16'o160000, 4'b0010, 16'o020, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'o020000, 4'b0001, 16'o000, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'o000100, 4'b0000, 16'o000, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'o000351, 4'b1000, 16'o104, 1'b0, 1'b1}
  };
  localparam string VTAG [NV] = '{"R5", "R3", "R3", "R4", "R4", "R6", "R7",
                                  "R8", "R8", "R9", "R9", "R9", "R9", "R5", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_push = 1'b0;
  logic        acc_kernel = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        ab_odd = 1'b0;
  logic        ab_nxm = 1'b0;
  logic        ab_iobto = 1'b0;
  logic        ab_mmu = 1'b0;
  logic        halt_user = 1'b0;
  logic        reg_wr = 1'b0;
  logic        yel_trap;
  logic        red_abort;
  logic        halt_trap;
  logic [15:0] err_q;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuerr_stack_mon u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_push(acc_push),
    .acc_kernel(acc_kernel), .acc_addr(acc_addr), .ab_odd(ab_odd),
    .ab_nxm(ab_nxm), .ab_iobto(ab_iobto), .ab_mmu(ab_mmu),
    .halt_user(halt_user), .reg_wr(reg_wr), .yel_trap(yel_trap),
    .red_abort(red_abort), .halt_trap(halt_trap), .err_q(err_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 1'b0; acc_push = 1'b0; acc_kernel = 1'b0; acc_addr = '0;
    {ab_odd, ab_nxm, ab_iobto, ab_mmu} = 4'b0000;
    halt_user = 1'b0; reg_wr = 1'b0;
  endtask

  // inputs change on the falling edge; one rising edge later results are visible
  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_write();
    reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic do_access(input logic p, input logic k, input logic [15:0] a,
                           input logic [3:0] c);
    acc_valid = 1'b1; acc_push = p; acc_kernel = k; acc_addr = a;
    {ab_odd, ab_nxm, ab_iobto, ab_mmu} = c;
    step();
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) step();
    // R1: reset state while reset is held and right after release
    check("R1", "err in reset", err_q, 16'o0);
    check("R1", "requests in reset", {13'b0, yel_trap, red_abort, halt_trap}, 16'o0);
    rst_n = 1'b1;
    step();
    check("R1", "err after release", err_q, 16'o0);
    check("R1", "requests after release", {13'b0, yel_trap, red_abort, halt_trap}, 16'o0);

    // table walk: R3..R9
    for (int i = 0; i < NV; i++) begin
      do_write();
      do_access(VEC[i][39], VEC[i][38], VEC[i][37:22], VEC[i][21:18]);
      check(VTAG[i], $sformatf("vector %0d err", i), err_q, VEC[i][17:2]);
      check(VTAG[i], $sformatf("vector %0d yel", i), {15'b0, yel_trap}, {15'b0, VEC[i][1]});
      check(VTAG[i], $sformatf("vector %0d red", i), {15'b0, red_abort}, {15'b0, VEC[i][0]});
    end

    // R12: pulse lasts one cycle; status stays
    do_write();
    do_access(1'b1, 1'b1, 16'o000200, 4'b0000);
    step();
    check("R12", "red pulse dropped", {15'b0, red_abort}, 16'o0);
    check("R12", "status held", err_q, 16'o004);

    // R12: access fields ignored while acc_valid low
    do_write();
    acc_push = 1'b1; acc_kernel = 1'b1; acc_addr = 16'o000010; ab_odd = 1'b1;
    step();
    idle_inputs();
    check("R12", "invalid access err", err_q, 16'o0);
    check("R12", "invalid access red", {15'b0, red_abort}, 16'o0);

    // R10: user-mode halt
    halt_user = 1'b1;
    step();
    halt_user = 1'b0;
    check("R10", "halt err", err_q, 16'o200);
    check("R10", "halt trap", {15'b0, halt_trap}, 16'o1);

    // R11: accumulate with a yellow push
    do_access(1'b1, 1'b1, 16'o000360, 4'b0000);
    check("R11", "accumulate", err_q, 16'o210);

    // R2: write clears all
    do_write();
    check("R2", "write clears", err_q, 16'o0);

    // R11: event in same cycle as write survives
    do_access(1'b0, 1'b1, 16'o000001, 4'b1000);
    reg_wr = 1'b1; halt_user = 1'b1;
    step();
    idle_inputs();
    check("R11", "write plus halt", err_q, 16'o200);

    // R13: every cause together gives exactly the implemented bits
    do_write();
    do_access(1'b0, 1'b1, 16'o000001, 4'b1000);
    do_access(1'b0, 1'b1, 16'o140000, 4'b0100);
    do_access(1'b0, 1'b1, 16'o160000, 4'b0010);
    do_access(1'b1, 1'b1, 16'o000370, 4'b0000);
    do_access(1'b1, 1'b1, 16'o000100, 4'b0000);
    halt_user = 1'b1;
    step();
    halt_user = 1'b0;
    check("R13", "all causes", err_q, 16'o374);

    // R1: reset mid-run clears
    rst_n = 1'b0;
    step();
    check("R1", "reset clears", err_q, 16'o0);
    rst_n = 1'b1;
    step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule